// File: doc/BRIEF.md
# Stop Mode Entry Controller

This block sequences a small microcontroller into and out of its low-power stop states. The CPU sends a one-cycle request when it executes a stop instruction. On that request the block reads a set of configuration inputs and decides whether stop is allowed. If it is not, the block raises an illegal-opcode reset request. If it is, the block picks one of five stop levels.

While stopped, the block holds the CPU and bus clock enables low. Its outputs tell the clock generator, the regulator and the display driver what must stay powered. It also enables the real-time tick oscillator when a nonzero rate is selected.

The block watches the reset pin and five wakeup sources, and filters them by what the latched stop level can accept. It reports one wake cause and whether the system resumes through the reset vector or through an interrupt vector. One cycle later it returns the system to run mode.

Top module: `stop_entry_ctrl`

## Requirements
- R1: A stop request while `stop_en` is 0 makes `illegal_rst` high for exactly the next cycle. `stop_mode` stays 0 and `cpu_clk_en` stays 1.
- R2: With `stop_en`=1 and `dbg_en`=1, the block enters `stop_mode`=1 (stop3 with debug), whatever the voltage-detect and power-down inputs are. In this mode both `ref_clk_keep` and `reg_keep` are 1.
- R3: With `stop_en`=1, `dbg_en`=0, `lvd_en`=1 and `lvd_stop_en`=1, the block enters `stop_mode`=2 (stop3, regulator on). In this mode `reg_keep`=1 and `ref_clk_keep`=0.
- R4: With `stop_en`=1 and `dbg_en`=0, when voltage detect in stop is not fully enabled and `pwr_down`=0, the block enters `stop_mode`=3 (plain stop3). Both `reg_keep` and `ref_clk_keep` are 0.
- R5: Under the same conditions with `pwr_down`=1, `part_pwr_down`=1 gives `stop_mode`=4 (stop2) and `part_pwr_down`=0 gives `stop_mode`=5 (stop1).
- R6: While `stop_mode` is nonzero, `cpu_clk_en` and `bus_clk_en` are both 0. Out of reset and in run mode they are both 1 and `stop_mode` is 0.
- R7: The wake inputs are indexed 0 reset pin, 1 real-time tick, 2 voltage detect, 3 ADC, 4 external IRQ, 5 keyboard. Every stop3 level accepts all six. Stop2 accepts only 0, 1 and 4. Stop1 accepts only 0 and 4. An input a level does not accept leaves the block stopped.
- R8: On a wake, `wake_rst_vec`=1 when the cause is the reset pin or the level was stop2 or stop1. Otherwise it is 0, meaning an interrupt vector.
- R9: The real-time tick can wake the block only if `rti_sel` was nonzero when the stop was requested. `rti_osc_en` is 1 exactly when the relevant `rti_sel` is nonzero: the live value in run mode, the latched value while stopped.
- R10: `lcd_keep` is 1 only while in a stop3 level (`stop_mode` 1 to 3) and only if `lcd_s3_en` was 1 at the request.
- R11: The level, the LCD enable and the rate select are latched at the request. Later changes to any configuration input, and further stop requests while stopped, have no effect until the next request from run mode.
- R12: Accepted wake inputs that arrive together are resolved by index, lowest index first. `wake_src` is index+1. `wake_pulse` is high for the one cycle after the wake inputs are sampled, with the clocks still off. The clock enables return to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle pulse when a stop instruction executes |
| stop_en | input | 1 | Stop permitted |
| dbg_en | input | 1 | Debug interface enabled |
| lvd_en | input | 1 | Low-voltage detect enabled |
| lvd_stop_en | input | 1 | Low-voltage detect kept on in stop |
| pwr_down | input | 1 | Power-down request bit |
| part_pwr_down | input | 1 | Partial power-down select (1 gives stop2, 0 gives stop1) |
| rti_sel | input | RTI_W | Real-time tick rate select; 0 disables the tick |
| lcd_s3_en | input | 1 | Keep the display driver running in stop3 |
| reset_pin | input | 1 | Reset pin asserted |
| rti_tick | input | 1 | Real-time tick interrupt |
| lvd_irq | input | 1 | Low-voltage detect interrupt |
| adc_irq | input | 1 | ADC interrupt |
| ext_irq | input | 1 | External IRQ pin interrupt |
| kbd_irq | input | 1 | Keyboard interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| ref_clk_keep | output | 1 | Keep reference clocks running in stop |
| reg_keep | output | 1 | Keep the regulator active in stop |
| lcd_keep | output | 1 | Keep the display driver running in stop |
| rti_osc_en | output | 1 | Enable the self-clocked tick oscillator |
| illegal_rst | output | 1 | Illegal-opcode reset request |
| stop_mode | output | 3 | 0 run, 1 stop3 debug, 2 stop3 regulator, 3 stop3, 4 stop2, 5 stop1 |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_src | output | 3 | Wake cause, index+1; 0 when no wake |
| wake_rst_vec | output | 1 | 1 resume through reset vector, 0 through interrupt vector |

## Verification
The bench sweeps all 64 combinations of the six enable bits against all 63 non-empty patterns of wake inputs. It therefore catches a decode with a wrong priority, for example one that lets the power-down bits override debug. It also catches a level that wakes on a source it should ignore, which would leave stop with the wrong wake cause or at the wrong moment.

While the block is stopped, the bench inverts every configuration input and clears the rate select. A design that failed to latch its configuration would change its reported level, lose its keep flags, or refuse the tick wake. It would also stop filtering wake sources by the mode it entered and use the new configuration instead.

A stop request arriving during stop, with stop disabled, must raise no illegal reset. Separate checks confirm that a wake with a rate select of zero is ignored, and that the clocks stay off through the wake cycle.

// File: rtl/stop_entry_pkg.sv
package stop_entry_pkg;

  localparam int MODE_W = 3;
  localparam int N_WAKE = 6;
  localparam int SRC_W  = $clog2(N_WAKE + 1);

  // wake input index
  localparam int WK_RST = 0;
  localparam int WK_RTI = 1;
  localparam int WK_LVD = 2;
  localparam int WK_ADC = 3;
  localparam int WK_IRQ = 4;
  localparam int WK_KBD = 5;

  typedef enum logic [MODE_W-1:0] {
    MD_RUN    = 3'd0,
    MD_S3_DBG = 3'd1,
    MD_S3_REG = 3'd2,
    MD_S3     = 3'd3,
    MD_S2     = 3'd4,
    MD_S1     = 3'd5
  } stop_mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic stop_en;
    logic dbg_en;
    logic lvd_en;
    logic lvd_stop_en;
    logic pwr_down;
    logic part_pwr_down;
  } stop_cfg_t;

  // priority decision over the enables; MD_RUN means stop is not permitted
  function automatic stop_mode_e resolve_mode(stop_cfg_t c);
    stop_mode_e m;
    if (!c.stop_en)                     m = MD_RUN;
    else if (c.dbg_en)                  m = MD_S3_DBG;
    else if (c.lvd_en && c.lvd_stop_en) m = MD_S3_REG;
    else if (!c.pwr_down)               m = MD_S3;
    else if (c.part_pwr_down)           m = MD_S2;
    else                                m = MD_S1;
    return m;
  endfunction

  function automatic logic is_stop3(stop_mode_e m);
    return (m == MD_S3_DBG) || (m == MD_S3_REG) || (m == MD_S3);
  endfunction

  // which wake inputs a given level listens to
  function automatic logic [N_WAKE-1:0] accept_mask(stop_mode_e m, logic rti_live);
    logic [N_WAKE-1:0] k;
    k = '0;
    k[WK_RST] = 1'b1;
    k[WK_IRQ] = 1'b1;
    if (is_stop3(m)) begin
      k[WK_LVD] = 1'b1;
      k[WK_ADC] = 1'b1;
      k[WK_KBD] = 1'b1;
    end
    k[WK_RTI] = rti_live && (m != MD_S1);
    return k;
  endfunction

  // lowest index wins; code is index+1, 0 when nothing pending
  function automatic logic [SRC_W-1:0] pick_src(logic [N_WAKE-1:0] req);
    logic [SRC_W-1:0] s;
    s = '0;
    for (int i = N_WAKE - 1; i >= 0; i--) begin
      if (req[i]) s = SRC_W'(i + 1);
    end
    return s;
  endfunction

  function automatic logic via_reset_vec(stop_mode_e m, logic [SRC_W-1:0] s);
    return (s == SRC_W'(WK_RST + 1)) || (m == MD_S2) || (m == MD_S1);
  endfunction

endpackage

// File: rtl/stop_mode_resolve.sv
module stop_mode_resolve
  import stop_entry_pkg::*;
(
  input  logic       stop_en,
  input  logic       dbg_en,
  input  logic       lvd_en,
  input  logic       lvd_stop_en,
  input  logic       pwr_down,
  input  logic       part_pwr_down,
  output stop_mode_e mode_o,
  output logic       illegal_o
);

  stop_cfg_t cfg;

  always_comb begin
    cfg.stop_en       = stop_en;
    cfg.dbg_en        = dbg_en;
    cfg.lvd_en        = lvd_en;
    cfg.lvd_stop_en   = lvd_stop_en;
    cfg.pwr_down      = pwr_down;
    cfg.part_pwr_down = part_pwr_down;
  end

  assign mode_o    = resolve_mode(cfg);
  assign illegal_o = (mode_o == MD_RUN);

endmodule

// File: rtl/stop_wake_arb.sv
module stop_wake_arb
  import stop_entry_pkg::*;
#(
  parameter int NW = N_WAKE,
  parameter int SW = SRC_W
) (
  input  logic [NW-1:0] req_i,
  input  logic [NW-1:0] mask_i,
  output logic          hit_o,
  output logic [SW-1:0] src_o
);

  logic [NW-1:0] live;

  for (genvar g = 0; g < NW; g++) begin : g_gate
    assign live[g] = req_i[g] & mask_i[g];
  end

  assign hit_o = |live;
  assign src_o = SW'(pick_src(N_WAKE'(live)));

endmodule

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
  import stop_entry_pkg::*;
#(
  parameter int SW = SRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  stop_mode_e    mode_in,
  input  logic          illegal_in,
  input  logic          lcd_in,
  input  logic          rti_nz_in,
  input  logic          wake_hit,
  input  logic [SW-1:0] wake_code,
  output seq_state_e    state_o,
  output stop_mode_e    mode_q_o,
  output logic          lcd_q_o,
  output logic          rti_q_o,
  output logic          illegal_q_o,
  output logic [SW-1:0] src_q_o,
  output logic          rvec_q_o,
  output logic          enter_stop_o
);

  seq_state_e    state;
  stop_mode_e    mode_q;
  logic          lcd_q, rti_q, illegal_q, rvec_q;
  logic [SW-1:0] src_q;
  logic          enter_stop, raise_illegal, take_wake;

  assign enter_stop    = (state == ST_RUN) && stop_req && !illegal_in;
  assign raise_illegal = (state == ST_RUN) && stop_req && illegal_in;
  assign take_wake     = (state == ST_STOP) && wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      mode_q    <= MD_RUN;
      lcd_q     <= 1'b0;
      rti_q     <= 1'b0;
      illegal_q <= 1'b0;
      src_q     <= '0;
      rvec_q    <= 1'b0;
    end else begin
      illegal_q <= raise_illegal;
      unique case (state)
        ST_RUN: begin
          if (enter_stop) begin
            state  <= ST_STOP;
            mode_q <= mode_in;
            lcd_q  <= lcd_in;
            rti_q  <= rti_nz_in;
          end
        end
        ST_STOP: begin
          if (take_wake) begin
            state  <= ST_WAKE;
            src_q  <= wake_code;
            rvec_q <= via_reset_vec(mode_q, SRC_W'(wake_code));
          end
        end
        ST_WAKE: begin
          state  <= ST_RUN;
          mode_q <= MD_RUN;
          lcd_q  <= 1'b0;
          src_q  <= '0;
          rvec_q <= 1'b0;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign state_o      = state;
  assign mode_q_o     = mode_q;
  assign lcd_q_o      = lcd_q;
  assign rti_q_o      = rti_q;
  assign illegal_q_o  = illegal_q;
  assign src_q_o      = src_q;
  assign rvec_q_o     = rvec_q;
  assign enter_stop_o = enter_stop;

endmodule

// File: rtl/stop_entry_ctrl.sv
module stop_entry_ctrl
  import stop_entry_pkg::*;
#(
  parameter int RTI_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             stop_en,
  input  logic             dbg_en,
  input  logic             lvd_en,
  input  logic             lvd_stop_en,
  input  logic             pwr_down,
  input  logic             part_pwr_down,
  input  logic [RTI_W-1:0] rti_sel,
  input  logic             lcd_s3_en,
  input  logic             reset_pin,
  input  logic             rti_tick,
  input  logic             lvd_irq,
  input  logic             adc_irq,
  input  logic             ext_irq,
  input  logic             kbd_irq,
  output logic             cpu_clk_en,
  output logic             bus_clk_en,
  output logic             ref_clk_keep,
  output logic             reg_keep,
  output logic             lcd_keep,
  output logic             rti_osc_en,
  output logic             illegal_rst,
  output logic [MODE_W-1:0] stop_mode,
  output logic             wake_pulse,
  output logic [SRC_W-1:0] wake_src,
  output logic             wake_rst_vec
);

  stop_mode_e       req_mode, mode_q;
  logic             req_illegal;
  seq_state_e       state;
  logic             lcd_q, rti_q, illegal_q, rvec_q;
  logic [SRC_W-1:0] src_q, wake_code;
  logic [N_WAKE-1:0] wake_req, wake_mask;
  logic             wake_hit, enter_stop, stopped, rti_live;

  assign rti_live = (rti_sel != '0);

  stop_mode_resolve u_resolve (
    .stop_en       (stop_en),
    .dbg_en        (dbg_en),
    .lvd_en        (lvd_en),
    .lvd_stop_en   (lvd_stop_en),
    .pwr_down      (pwr_down),
    .part_pwr_down (part_pwr_down),
    .mode_o        (req_mode),
    .illegal_o     (req_illegal)
  );

  always_comb begin
    wake_req         = '0;
    wake_req[WK_RST] = reset_pin;
    wake_req[WK_RTI] = rti_tick;
    wake_req[WK_LVD] = lvd_irq;
    wake_req[WK_ADC] = adc_irq;
    wake_req[WK_IRQ] = ext_irq;
    wake_req[WK_KBD] = kbd_irq;
  end

  assign wake_mask = accept_mask(mode_q, rti_q);

  stop_wake_arb u_arb (
    .req_i  (wake_req),
    .mask_i (wake_mask),
    .hit_o  (wake_hit),
    .src_o  (wake_code)
  );

  stop_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .mode_in      (req_mode),
    .illegal_in   (req_illegal),
    .lcd_in       (lcd_s3_en),
    .rti_nz_in    (rti_live),
    .wake_hit     (wake_hit),
    .wake_code    (wake_code),
    .state_o      (state),
    .mode_q_o     (mode_q),
    .lcd_q_o      (lcd_q),
    .rti_q_o      (rti_q),
    .illegal_q_o  (illegal_q),
    .src_q_o      (src_q),
    .rvec_q_o     (rvec_q),
    .enter_stop_o (enter_stop)
  );

  assign stopped      = (state != ST_RUN);
  assign cpu_clk_en   = !stopped;
  assign bus_clk_en   = !stopped;
  assign ref_clk_keep = stopped && (mode_q == MD_S3_DBG);
  assign reg_keep     = stopped && ((mode_q == MD_S3_DBG) || (mode_q == MD_S3_REG));
  assign lcd_keep     = stopped && lcd_q && is_stop3(mode_q);
  assign rti_osc_en   = stopped ? rti_q : rti_live;
  assign illegal_rst  = illegal_q;
  assign stop_mode    = mode_q;
  assign wake_pulse   = (state == ST_WAKE);
  assign wake_src     = src_q;
  assign wake_rst_vec = rvec_q;

endmodule

// File: rtl/stop_entry_chk.sv
module stop_entry_chk
  import stop_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              stop_en,
  input logic              cpu_clk_en,
  input logic              bus_clk_en,
  input logic              ref_clk_keep,
  input logic              reg_keep,
  input logic              lcd_keep,
  input logic              rti_osc_en,
  input logic              illegal_rst,
  input logic [MODE_W-1:0] stop_mode,
  input logic              wake_pulse,
  input logic [SRC_W-1:0]  wake_src,
  input logic              wake_rst_vec,
  input logic              wake_hit,
  input logic              enter_stop
);

  // R1
  illegal_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_en && cpu_clk_en) |=> (illegal_rst && stop_mode == '0 && cpu_clk_en));

  // R2
  dbg_keeps_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode == 3'd1) |-> (ref_clk_keep && reg_keep));

  // R6
  clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode != '0) |-> (!cpu_clk_en && !bus_clk_en));

  // R8
  pin_reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && wake_src == SRC_W'(1)) |-> wake_rst_vec);

  // R9
  rti_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && wake_src == SRC_W'(2)) |-> rti_osc_en);

  // R10
  lcd_only_s3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_keep |-> (stop_mode >= 3'd1 && stop_mode <= 3'd3));

  // R11
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode != '0 && !wake_pulse) |=> $stable(stop_mode));

  // R11
  enter_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stop |=> (stop_mode != '0));

  // R12
  wake_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && !cpu_clk_en && !wake_pulse) |=> (wake_pulse && !cpu_clk_en));

  // R12
  clk_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> (cpu_clk_en && bus_clk_en && !wake_pulse));

  // R12
  src_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (wake_src != '0));

endmodule

bind stop_entry_ctrl stop_entry_chk u_chk (.*);

// File: tb/stop_entry_ctrl_tb_top.sv
module stop_entry_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, stop_en = 0, dbg_en = 0, lvd_en = 0, lvd_stop_en = 0;
  logic pwr_down = 0, part_pwr_down = 0, lcd_s3_en = 0;
  logic [2:0] rti_sel = 3'd0;
  logic reset_pin = 0, rti_tick = 0, lvd_irq = 0, adc_irq = 0, ext_irq = 0, kbd_irq = 0;
  logic cpu_clk_en, bus_clk_en, ref_clk_keep, reg_keep, lcd_keep, rti_osc_en;
  logic illegal_rst, wake_pulse, wake_rst_vec;
  logic [2:0] stop_mode, wake_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stop_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_en(stop_en), .dbg_en(dbg_en),
    .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en), .pwr_down(pwr_down),
    .part_pwr_down(part_pwr_down), .rti_sel(rti_sel), .lcd_s3_en(lcd_s3_en),
    .reset_pin(reset_pin), .rti_tick(rti_tick), .lvd_irq(lvd_irq), .adc_irq(adc_irq),
    .ext_irq(ext_irq), .kbd_irq(kbd_irq), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .ref_clk_keep(ref_clk_keep), .reg_keep(reg_keep), .lcd_keep(lcd_keep),
    .rti_osc_en(rti_osc_en), .illegal_rst(illegal_rst), .stop_mode(stop_mode),
    .wake_pulse(wake_pulse), .wake_src(wake_src), .wake_rst_vec(wake_rst_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // bits of c: 5 stop_en, 4 dbg, 3 lvd_en, 2 lvd_stop, 1 pwr_down, 0 part
  function automatic int want_mode(input logic [5:0] c);
    if (c[5] == 1'b0) return 0;
    if (c[4]) return 1;
    if (c[3] & c[2]) return 2;
    if (!c[1]) return 3;
    return c[0] ? 4 : 5;
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  // w index: 0 pin, 1 tick, 2 lvd, 3 adc, 4 irq, 5 kbd
  function automatic bit listens(input int m, input int idx, input bit rti_nz);
    case (idx)
      0, 4: return 1'b1;
      1:    return rti_nz && (m != 5);
      default: return m <= 3;
    endcase
  endfunction

  function automatic int want_src(input int m, input logic [5:0] w, input bit rti_nz);
    for (int i = 0; i < 6; i++) if (w[i] && listens(m, i, rti_nz)) return i + 1;
    return 0;
  endfunction

  task automatic put_cfg(input logic [5:0] c);
    {stop_en, dbg_en, lvd_en, lvd_stop_en, pwr_down, part_pwr_down} = c;
  endtask

  task automatic put_wake(input logic [5:0] w);
    {kbd_irq, ext_irq, adc_irq, lvd_irq, rti_tick, reset_pin} = w;
  endtask

  task automatic run_case(input logic [5:0] c, input logic [2:0] rs, input bit lcd,
                          input logic [5:0] w);
    int m, s;
    bit rnz;
    m = want_mode(c);
    rnz = (rs != 3'd0);
    @(negedge clk);
    put_cfg(c); rti_sel = rs; lcd_s3_en = lcd; stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    if (m == 0) begin
      eq("R1 illegal_rst", illegal_rst, 1);
      eq("R1 stop_mode", stop_mode, 0);
      eq("R1 cpu_clk_en", cpu_clk_en, 1);
      @(negedge clk);
      eq("R1 illegal one cycle", illegal_rst, 0);
      return;
    end
    eq({mode_tag(m), " stop_mode"}, stop_mode, m);
    eq("R6 cpu_clk_en", cpu_clk_en, 0);
    eq("R6 bus_clk_en", bus_clk_en, 0);
    eq({mode_tag(m), " ref_clk_keep"}, ref_clk_keep, (m == 1) ? 1 : 0);
    eq({mode_tag(m), " reg_keep"}, reg_keep, (m == 1 || m == 2) ? 1 : 0);
    eq("R10 lcd_keep", lcd_keep, (lcd && m <= 3) ? 1 : 0);
    eq("R9 rti_osc_en", rti_osc_en, rnz ? 1 : 0);
    // disturb every configuration input while stopped
    put_cfg(~c); rti_sel = 3'd0; lcd_s3_en = ~lcd;
    put_wake(w);
    s = want_src(m, w, rnz);
    @(negedge clk);
    eq("R11 stop_mode latched", stop_mode, m);
    eq("R11 lcd_keep latched", lcd_keep, (lcd && m <= 3) ? 1 : 0);
    if (s != 0) begin
      eq("R12 wake_pulse", wake_pulse, 1);
      eq("R12 wake_src", wake_src, s);
      eq("R8 wake_rst_vec", wake_rst_vec, (s == 1 || m >= 4) ? 1 : 0);
      eq("R12 clocks off in wake cycle", cpu_clk_en, 0);
      put_wake(6'd0);
      @(negedge clk);
      eq("R12 cpu_clk_en back", cpu_clk_en, 1);
      eq("R6 bus_clk_en back", bus_clk_en, 1);
      eq("R6 stop_mode run", stop_mode, 0);
      eq("R9 rti_osc_en live", rti_osc_en, 0);
    end else begin
      eq("R7 ignored wake", wake_pulse, 0);
      @(negedge clk);
      eq("R7 still stopped", stop_mode, m);
      eq("R7 no wake", wake_pulse, 0);
      put_wake(6'b000001);
      @(negedge clk);
      eq("R7 pin wake", wake_pulse, 1);
      eq("R8 pin src", wake_src, 1);
      eq("R8 pin vector", wake_rst_vec, 1);
      put_wake(6'd0);
      @(negedge clk);
      eq("R12 cpu_clk_en back", cpu_clk_en, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    eq("R6 reset cpu_clk_en", cpu_clk_en, 1);
    eq("R6 reset bus_clk_en", bus_clk_en, 1);
    eq("R6 reset stop_mode", stop_mode, 0);
    eq("R1 reset illegal_rst", illegal_rst, 0);
    eq("R12 reset wake_pulse", wake_pulse, 0);

    // full sweep of enables against wake patterns
    for (int c = 0; c < 64; c++) begin
      if (c < 32) begin
        run_case(6'(c), 3'd2, 1'b1, 6'd0);
      end else begin
        for (int w = 1; w < 64; w++) begin
          logic [2:0] rs;
          rs = k[0] ? 3'd0 : (3'd7 ^ {1'b0, 2'(k >> 1)});
          run_case(6'(c), rs, k[1], 6'(w));
          k++;
        end
      end
    end

    // R9: tick alone with rate select zero is ignored in plain stop3
    run_case(6'b100000, 3'd0, 1'b0, 6'b000010);
    // R9: same with nonzero rate wakes through interrupt vector
    run_case(6'b100000, 3'd1, 1'b0, 6'b000010);

    // R11: stop request during stop, with stop disabled, is ignored
    @(negedge clk);
    put_cfg(6'b100000); rti_sel = 3'd0; stop_req = 1;
    @(negedge clk);
    stop_req = 1; stop_en = 0;
    @(negedge clk);
    stop_req = 0;
    eq("R11 no illegal while stopped", illegal_rst, 0);
    eq("R11 mode kept", stop_mode, 3);
    @(negedge clk);
    eq("R11 illegal stays low", illegal_rst, 0);
    adc_irq = 1;
    @(negedge clk);
    adc_irq = 0;
    eq("R12 adc src", wake_src, 4);
    eq("R8 interrupt vector", wake_rst_vec, 0);
    @(negedge clk);
    eq("R12 run again", cpu_clk_en, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule